// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a countdown watchdog driven by a small word-wide register interface. Software programs a timeout in ticks, picks one of four tick periods and a global enable, then sets the run bit and writes a trigger to load the counter. Periodic triggers keep the counter away from zero. If the counter reaches zero, the block raises a one-cycle request, either a reboot (reset) request or a shutdown request, as chosen by an action bit. It also sets a sticky fired flag. The system reset does not clear this flag, so software can see after a reboot that the watchdog caused it.

The tick comes from a prescaler built from the clock frequency parameter, so every resolution setting gives an exact period. The register port is a plain single-cycle access with no valid/ready handshake. A write is taken on any clock edge where `bus_we` is high. Reads are combinational from `bus_addr`, so the port never applies back-pressure. There are two reset inputs. `por_n` clears everything. `sys_rst_n` clears everything except the fired flag.

Top module: `wdt_top`

## Requirements
- R1: Word 1 is the count register. A write stores bits 15:0 as the timeout in ticks and ignores bits 31:16. A read returns the remaining count in bits 15:0 with zeros above. Word 0 is control. Word 2 is configuration.
- R2: The counter decrements only while the global enable (config bit 0) and the run bit (control bit 0) are both 1. Clearing run freezes the remaining count, and no expiry follows.
- R3: Writing 1 to control bit 1 (trigger) reloads the counter from the timeout and restarts the prescaler. Bit 1 always reads 0. One write with run and trigger both set loads and starts the counter together.
- R4: Config bits 2:1 select the tick period: 0 = 32 us, 1 = 10 ms, 2 = 100 ms, 3 = 1 s. With timeout N and a period of D clocks, expiry is visible exactly N*D cycles after the clock edge that took the trigger.
- R5: A config write that changes the resolution restarts the prescaler from zero.
- R6: On expiry, `reset_req` pulses high for one clock when control bit 3 (action) is 0, and `shutdown_req` pulses when it is 1. The counter then stays at 0 until the next trigger.
- R7: Control bit 2 (fired) is set on expiry. Writing 1 to it clears it, and writing 0 has no effect. It survives `sys_rst_n` and is cleared only by `por_n`.
- R8: While the global enable is 0, the counter does not count and triggers are ignored.
- R9: After reset, control reads 0, count reads 0, configuration reads 6 (disabled, 1 s resolution), and both requests are low.
- R10: A trigger with a timeout of 0 leaves the counter at 0 and never produces a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| sys_rst_n | input | 1 | System reset, active low, keeps the fired flag |
| bus_addr | input | 2 | Register word select |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| reset_req | output | 1 | One-cycle reboot request on expiry |
| shutdown_req | output | 1 | One-cycle shutdown request on expiry |

## Verification
The embedded assertions check on every cycle that:
- a request is never longer than one clock;
- the counter sits at zero whenever a request is raised;
- the counter holds its value whenever there is no tick and no reload;
- the fired flag follows every request and stays set until a clear write.

Only the bench scenarios can show:
- that expiry lands on the exact cycle predicted for each resolution;
- that a resolution change realigns the tick;
- that the fired flag survives the system reset but not power-on reset;
- that writes are ignored while the global enable is clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    RES_32US  = 2'd0,
    RES_10MS  = 2'd1,
    RES_100MS = 2'd2,
    RES_1S    = 2'd3
  } res_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_COUNT = 2'd1;
  localparam logic [1:0] ADDR_CFG   = 2'd2;

  localparam int CTL_RUN   = 0;
  localparam int CTL_TRIG  = 1;
  localparam int CTL_FIRED = 2;
  localparam int CTL_ACT   = 3;
  localparam int CFG_EN    = 0;
  localparam int CFG_RES   = 1;

  // clocks per tick for a resolution code
  function automatic int unsigned res_div(input int unsigned code, input int unsigned clk_hz);
    case (code)
      0:       return clk_hz / 31250;
      1:       return clk_hz / 100;
      2:       return clk_hz / 10;
      default: return clk_hz;
    endcase
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int unsigned CLK_HZ = 62500,
  parameter int unsigned CNT_W  = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active_i,
  input  logic       restart_i,
  input  res_e       res_i,
  output logic       tick_o
);

  localparam int NRES = 4;

  logic [CNT_W-1:0] div_tab [NRES];
  logic [CNT_W-1:0] pre_q;
  logic [CNT_W-1:0] last_val;

  for (genvar g = 0; g < NRES; g++) begin : g_div
    assign div_tab[g] = CNT_W'(res_div(g, CLK_HZ) - 1);
  end

  assign last_val = div_tab[res_i];
  assign tick_o   = active_i && !restart_i && (pre_q == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pre_q <= '0;
    else if (restart_i || !active_i || tick_o) pre_q <= '0;
    else                           pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TMO_W-1:0] load_val_i,
  input  logic             active_i,
  input  logic             tick_i,
  output logic [TMO_W-1:0] remain_o,
  output logic             expire_o
);

  logic [TMO_W-1:0] cnt_q;
  logic             exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (load_i) begin
        cnt_q <= load_val_i;
      end else if (active_i && tick_i && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == TMO_W'(1)) exp_q <= 1'b1;
      end
    end
  end

  assign remain_o = cnt_q;
  assign expire_o = exp_q;

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(active_i && tick_i) && !load_i) |=> $stable(cnt_q));

  // R6
  zero_at_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |-> (cnt_q == '0));

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned TMO_W       = 16,
  parameter logic [15:0] DEF_TIMEOUT = 16'd100,
  parameter res_e        DEF_RES     = RES_1S
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [TMO_W-1:0]  remain_i,
  input  logic              expire_i,
  output logic              active_o,
  output logic              action_o,
  output res_e              res_o,
  output logic [TMO_W-1:0]  timeout_o,
  output logic              load_o,
  output logic              restart_o
);

  logic run_q, act_q, en_q, fired_q;
  res_e res_q;
  logic [TMO_W-1:0] tmo_q;
  logic wr_ctrl, wr_cnt, wr_cfg, fired_clr;
  res_e res_new;
  logic unused_wdata_bits;

  assign wr_ctrl   = bus_we && bus_addr == ADDR_CTRL;
  assign wr_cnt    = bus_we && bus_addr == ADDR_COUNT;
  assign wr_cfg    = bus_we && bus_addr == ADDR_CFG;
  assign fired_clr = wr_ctrl && bus_wdata[CTL_FIRED];
  assign res_new   = res_e'(bus_wdata[CFG_RES +: 2]);
  assign unused_wdata_bits = ^bus_wdata[DATA_W-1:TMO_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      act_q <= 1'b0;
      en_q  <= 1'b0;
      res_q <= DEF_RES;
      tmo_q <= TMO_W'(DEF_TIMEOUT);
    end else begin
      if (wr_ctrl) begin
        run_q <= bus_wdata[CTL_RUN];
        act_q <= bus_wdata[CTL_ACT];
      end
      if (wr_cnt) tmo_q <= bus_wdata[TMO_W-1:0];
      if (wr_cfg) begin
        en_q  <= bus_wdata[CFG_EN];
        res_q <= res_new;
      end
    end
  end

  // sticky flag on the power-on reset only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         fired_q <= 1'b0;
    else if (expire_i)  fired_q <= 1'b1;
    else if (fired_clr) fired_q <= 1'b0;
  end

  assign load_o    = wr_ctrl && bus_wdata[CTL_TRIG] && en_q;
  assign restart_o = load_o || (wr_cfg && res_new != res_q);
  assign active_o  = en_q && run_q;
  assign action_o  = act_q;
  assign res_o     = res_q;
  assign timeout_o = tmo_q;

  always_comb begin
    case (bus_addr)
      ADDR_CTRL:  bus_rdata = DATA_W'({act_q, fired_q, 1'b0, run_q});
      ADDR_COUNT: bus_rdata = DATA_W'(remain_i);
      ADDR_CFG:   bus_rdata = DATA_W'({res_q, en_q});
      default:    bus_rdata = '0;
    endcase
  end

  // R7
  fired_follows_expiry_chk: assert property (@(posedge clk) disable iff (!por_n)
    expire_i |=> fired_q);

  // R7
  fired_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    (fired_q && !fired_clr) |=> fired_q);

endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 62500,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned TMO_W       = 16,
  parameter logic [15:0] DEF_TIMEOUT = 16'd100,
  parameter res_e        DEF_RES     = RES_1S
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              reset_req,
  output logic              shutdown_req
);

  localparam int unsigned PRE_W = $clog2(CLK_HZ) + 1;

  logic rst_n;
  logic active, action, load, restart, tick, expire;
  res_e res;
  logic [TMO_W-1:0] timeout, remain;

  assign rst_n = por_n & sys_rst_n;

  wdt_regs #(
    .DATA_W(DATA_W), .TMO_W(TMO_W), .DEF_TIMEOUT(DEF_TIMEOUT), .DEF_RES(DEF_RES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .remain_i(remain), .expire_i(expire),
    .active_o(active), .action_o(action), .res_o(res), .timeout_o(timeout),
    .load_o(load), .restart_o(restart)
  );

  wdt_prescaler #(.CLK_HZ(CLK_HZ), .CNT_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .active_i(active), .restart_i(restart),
    .res_i(res), .tick_o(tick)
  );

  wdt_countdown #(.TMO_W(TMO_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(timeout),
    .active_i(active), .tick_i(tick), .remain_o(remain), .expire_o(expire)
  );

  assign reset_req    = expire && !action;
  assign shutdown_req = expire &&  action;

  // R6
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_req || shutdown_req) |=> !(reset_req || shutdown_req));

endmodule

// File: tb/sim_wdt_top.sv
module sim_wdt_top;

  localparam int CLK_PERIOD = 10;
  localparam int HZ = 62500;
  localparam int NVEC = 5;
  // {resolution, timeout, action}
  localparam logic [18:0] VEC [NVEC] = '{
    {2'd0, 16'd1,  1'b0},
    {2'd0, 16'd5,  1'b1},
    {2'd0, 16'd40, 1'b0},
    {2'd1, 16'd3,  1'b1},
    {2'd2, 16'd2,  1'b0}
  };

  logic clk = 1'b0;
  logic por_n = 1'b0, sys_rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic reset_req, shutdown_req;
  int tests = 0, fails = 0;
  logic [31:0] rv, v1;
  logic seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_top u0 (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .reset_req(reset_req), .shutdown_req(shutdown_req)
  );

  function automatic int div_of(input int code);
    case (code)
      0: return HZ / 31250;
      1: return HZ / 100;
      2: return HZ / 10;
      default: return HZ;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic quiet(input int n);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (reset_req || shutdown_req) seen = 1'b1;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; sys_rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 req", {30'd0, reset_req, shutdown_req}, 32'd0);
    rd(2'd0, rv); check("R9 ctrl", rv, 32'd0);
    rd(2'd1, rv); check("R9 count", rv, 32'd0);
    rd(2'd2, rv); check("R9 cfg", rv, 32'd6);

    // R8 trigger ignored while globally disabled
    wr(2'd0, 32'h3);
    quiet(50);
    check("R8 no req", {31'd0, seen}, 32'd0);
    rd(2'd1, rv); check("R8 count not loaded", rv, 32'd0);

    // R1 upper bits ignored, R3 trigger reads 0, R2 no count without run
    wr(2'd2, 32'h1);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'hABCD_0007);
    wr(2'd0, 32'h2);
    rd(2'd1, rv); check("R1 count low half", rv, 32'd7);
    rd(2'd0, rv); check("R3 trigger reads 0", rv, 32'd0);
    quiet(20);
    rd(2'd1, rv); check("R2 idle without run", rv, 32'd7);

    // R4 R6 R7 R3 vector table
    for (int k = 0; k < NVEC; k++) begin
      int rs, n, d;
      logic a;
      rs = int'(VEC[k][18:17]); n = int'(VEC[k][16:1]); a = VEC[k][0];
      d = div_of(rs);
      wr(2'd2, {29'd0, VEC[k][18:17], 1'b1});
      wr(2'd1, {16'd0, VEC[k][16:1]});
      wr(2'd0, {28'd0, a, 3'b111});
      repeat (n * d - 1) @(negedge clk);
      check("R4 no early expiry", {30'd0, reset_req, shutdown_req}, 32'd0);
      @(negedge clk);
      check("R6 request line", {30'd0, reset_req, shutdown_req}, {30'd0, !a, a});
      @(negedge clk);
      check("R6 one cycle", {30'd0, reset_req, shutdown_req}, 32'd0);
      rd(2'd0, rv); check("R7 fired set", {31'd0, rv[2]}, 32'd1);
      rd(2'd1, rv); check("R6 held at zero", rv, 32'd0);
    end

    // R7 survives system reset
    @(negedge clk); sys_rst_n = 1'b0;
    repeat (2) @(negedge clk); sys_rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, rv); check("R7 fired after sys reset", rv, 32'h4);
    rd(2'd2, rv); check("R9 cfg after sys reset", rv, 32'd6);

    // R7 write-0 no effect, write-1 clears
    wr(2'd0, 32'h0);
    rd(2'd0, rv); check("R7 write 0 keeps", rv, 32'h4);
    wr(2'd0, 32'h4);
    rd(2'd0, rv); check("R7 write 1 clears", rv, 32'h0);

    // R7 power-on reset clears
    wr(2'd2, 32'h1);
    wr(2'd1, 32'd1);
    wr(2'd0, 32'h3);
    repeat (3) @(negedge clk);
    rd(2'd0, rv); check("R7 fired again", rv, 32'h5);
    por_n = 1'b0;
    repeat (2) @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    rd(2'd0, rv); check("R7 cleared by por", rv, 32'h0);

    // R2 clearing run freezes the count
    wr(2'd2, 32'h1);
    wr(2'd1, 32'd10);
    wr(2'd0, 32'h3);
    repeat (7) @(negedge clk);
    wr(2'd0, 32'h0);
    rd(2'd1, v1); check("R2 frozen value", v1, 32'd6);
    quiet(40);
    check("R2 no expiry after stop", {31'd0, seen}, 32'd0);
    rd(2'd1, rv); check("R2 count stable", rv, v1);

    // R5 resolution change restarts prescaler
    wr(2'd2, 32'h3);
    wr(2'd1, 32'd1);
    wr(2'd0, 32'h3);
    repeat (600) @(negedge clk);
    wr(2'd2, 32'h1);
    check("R5 not yet", {31'd0, reset_req}, 32'd0);
    @(negedge clk);
    check("R5 not yet 2", {31'd0, reset_req}, 32'd0);
    @(negedge clk);
    check("R5 expiry after restart", {31'd0, reset_req}, 32'd1);

    // R10 zero timeout
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h7);
    quiet(30);
    check("R10 no request", {31'd0, seen}, 32'd0);
    rd(2'd1, rv); check("R10 count zero", rv, 32'd0);
    rd(2'd0, rv); check("R10 not fired", {31'd0, rv[2]}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule